// File: doc/BRIEF.md
# Store Queue with In-Order Writeback

This block holds stores from allocation until the data cache has accepted them. Entries sit in a circular buffer in program order. A store gets a slot at the tail when it is dispatched. Its address, data, byte size and prefetch flag are written into that slot when it executes. Once the pipeline declares a sequence number committed, every older store in the queue may be written to memory. Younger stores that are still speculative can be discarded from the tail by a squash.

Writeback keeps its own pointer, which sits between the oldest entry and the youngest. Each cycle it sends eligible stores in order to the cache, one per write lane, up to a fixed lane count. A write that hits finishes in the cycle it is sent. A write that misses finishes later, when the cache returns the slot index on a separate response input, and these responses may arrive in any order. The oldest entry is freed only once it and every entry after it, up to the first unfinished one, are complete. This keeps retirement in order even though completions are not.

Sequence numbers are compared as plain unsigned values, and a store is assumed to have executed before the commit number reaches it.

Top module: `store_wb_queue`

## Requirements
- R1: An allocation is accepted when the queue is not full and no squash is asserted in that cycle. The store lands at `tail_idx`, the tail advances and wraps from DEPTH-1 to 0, and `sq_count` rises by one. When `sq_count` equals DEPTH, `sq_full` is 1 and an allocation changes neither the count nor the tail.
- R2: A commit with number N walks from the oldest entry. It makes eligible every store whose sequence number is at most N. It stops at the first store that is not yet eligible and is younger than N, and no store from there on is written.
- R3: A store allocated as non-speculative becomes eligible when it executes without fault, with no commit needed. If it executes with a fault it is never written.
- R4: Eligible stores are written in queue order starting at the writeback pointer, at most PORTS per cycle. Lane 0 carries the oldest store of the cycle, and no store is written twice.
- R5: An eligible store of size 0 is completed without a write and does not take a lane, so PORTS stores behind it can still be written in the same cycle.
- R6: While `dc_blocked` is 1, no write is issued and nothing that needs a write completes.
- R7: An eligible prefetch store takes one lane slot in its cycle and is completed, but drives no write.
- R8: A write with its lane's `dc_hit` at 1 completes in its issue cycle. A write that misses stays outstanding until `resp_valid` returns its index.
- R9: The oldest entry is freed only when it is complete, together with every following complete entry up to the first incomplete one. Completions of younger entries alone leave `head_idx` and `sq_count` unchanged.
- R10: A squash with number S removes, walking back from the tail, every entry whose sequence number exceeds S. It rewinds `tail_idx` by the number removed and ignores an allocation in the same cycle.
- R11: After reset the queue is empty: `sq_count`=0, `head_idx`=`tail_idx`=0, `sq_full`=0 and no write lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the allocated store |
| alloc_nonspec | input | 1 | Store may write back without commit |
| exec_valid | input | 1 | Execute result for one slot |
| exec_idx | input | IW | Slot being executed |
| exec_addr | input | AW | Store address |
| exec_data | input | DW | Store data |
| exec_size | input | SZW | Store size in bytes, 0 for no access |
| exec_prefetch | input | 1 | Store is a prefetch hint |
| exec_fault | input | 1 | Execution faulted |
| commit_valid | input | 1 | Commit number presented |
| commit_seq | input | SEQW | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQW | Entries younger than this are removed |
| dc_blocked | input | 1 | Cache accepts no writes this cycle |
| dc_hit | input | PORTS | Per-lane hit result for this cycle's writes |
| resp_valid | input | 1 | Miss completion |
| resp_idx | input | IW | Slot of the completed miss |
| wr_valid | output | PORTS | Write lane valid |
| wr_idx | output | PORTS x IW | Slot index per lane |
| wr_addr | output | PORTS x AW | Write address per lane |
| wr_data | output | PORTS x DW | Write data per lane |
| wr_size | output | PORTS x SZW | Write size per lane |
| sq_full | output | 1 | Queue holds DEPTH stores |
| sq_count | output | CW | Occupied entries |
| head_idx | output | IW | Oldest entry |
| tail_idx | output | IW | Next allocation slot |

## Verification
Two completions can fall in the same cycle: a late miss response for the oldest entry, and a hit on a store that is issued in that very cycle. Both have to be folded into a single retirement step. The bench leaves the oldest store outstanding as a miss and completes the next one out of order through its response. It then commits a new store and, in the cycle that store is written with a hit, returns the response for the oldest entry. The check passes when all four entries free together at that clock edge, with `sq_count` going to zero and `head_idx` moving four places.

// File: rtl/swq_pkg.sv
package swq_pkg;

    // per-slot control state
    typedef struct packed {
        logic valid;
        logic nonspec;
        logic prefetch;
        logic elig;
        logic issued;
        logic done;
    } swq_flags_t;

    // circular index step, k may be negative
    function automatic int ring_step(int p, int k, int depth);
        return (((p + k) % depth) + depth) % depth;
    endfunction

endpackage

// File: rtl/swq_commit_scan.sv
module swq_commit_scan
    import swq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQW  = 16,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [DEPTH-1:0]           elig,
    input  logic [DEPTH-1:0][SEQW-1:0] seq,
    input  logic [IW-1:0]              head,
    input  logic [CW-1:0]              count,
    input  logic                       commit_valid,
    input  logic [SEQW-1:0]            commit_seq,
    output logic [DEPTH-1:0]           mark
);
    always_comb begin
        logic halt;
        int   idx;
        mark = '0;
        halt = !commit_valid;
        for (int k = 0; k < DEPTH; k++) begin
            idx = ring_step(int'(head), k, DEPTH);
            if (!halt && k < int'(count) && !elig[idx]) begin
                if (seq[idx] > commit_seq) halt = 1'b1;
                else                       mark[idx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swq_wb_walk.sv
module swq_wb_walk
    import swq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    parameter int SZW   = 4,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [DEPTH-1:0]          valid,
    input  logic [DEPTH-1:0]          elig,
    input  logic [DEPTH-1:0]          issued,
    input  logic [DEPTH-1:0]          prefetch,
    input  logic [DEPTH-1:0][SZW-1:0] size,
    input  logic [IW-1:0]             wb_ptr,
    input  logic [CW-1:0]             pending,
    input  logic                      blocked,
    output logic [PORTS-1:0]          lane_valid,
    output logic [PORTS-1:0][IW-1:0]  lane_idx,
    output logic [DEPTH-1:0]          issue_mask,
    output logic [DEPTH-1:0]          skip_done,
    output logic [IW-1:0]             wb_next
);
    always_comb begin
        int   ptr;
        int   used;
        int   pend;
        logic halt;
        lane_valid = '0;
        lane_idx   = '0;
        issue_mask = '0;
        skip_done  = '0;
        ptr  = int'(wb_ptr);
        used = 0;
        pend = int'(pending);
        halt = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!halt) begin
                if (pend == 0 || !valid[ptr] || !elig[ptr] || issued[ptr] || used >= PORTS) begin
                    halt = 1'b1;
                end else if (size[ptr] == '0) begin
                    // no memory access: finish without a lane
                    skip_done[ptr]  = 1'b1;
                    issue_mask[ptr] = 1'b1;
                    pend = pend - 1;
                    ptr  = ring_step(ptr, 1, DEPTH);
                end else if (blocked) begin
                    halt = 1'b1;
                end else begin
                    issue_mask[ptr] = 1'b1;
                    if (prefetch[ptr]) begin
                        skip_done[ptr] = 1'b1;
                    end else begin
                        lane_valid[used] = 1'b1;
                        lane_idx[used]   = IW'(ptr);
                    end
                    used = used + 1;
                    pend = pend - 1;
                    ptr  = ring_step(ptr, 1, DEPTH);
                end
            end
        end
        wb_next = IW'(ptr);
    end
endmodule

// File: rtl/swq_retire_scan.sv
module swq_retire_scan
    import swq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] done_n,
    input  logic [IW-1:0]    head,
    input  logic [CW-1:0]    count,
    output logic [DEPTH-1:0] retire_mask,
    output logic [CW-1:0]    retire_n,
    output logic [IW-1:0]    head_next
);
    always_comb begin
        logic halt;
        int   idx;
        int   n;
        retire_mask = '0;
        halt = 1'b0;
        n    = 0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = ring_step(int'(head), k, DEPTH);
            if (!halt && k < int'(count) && valid[idx] && done_n[idx]) begin
                retire_mask[idx] = 1'b1;
                n = n + 1;
            end else begin
                halt = 1'b1;
            end
        end
        retire_n  = CW'(n);
        head_next = IW'(ring_step(int'(head), n, DEPTH));
    end
endmodule

// File: rtl/swq_squash_scan.sv
module swq_squash_scan
    import swq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SEQW  = 16,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [DEPTH-1:0]           valid,
    input  logic [DEPTH-1:0][SEQW-1:0] seq,
    input  logic [IW-1:0]              tail,
    input  logic [CW-1:0]              count,
    input  logic                       squash_valid,
    input  logic [SEQW-1:0]            squash_seq,
    output logic [DEPTH-1:0]           kill_mask,
    output logic [CW-1:0]              kill_n,
    output logic [IW-1:0]              tail_next
);
    always_comb begin
        logic halt;
        int   idx;
        int   n;
        kill_mask = '0;
        halt = !squash_valid;
        n    = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            idx = ring_step(int'(tail), -k, DEPTH);
            if (!halt && k <= int'(count) && valid[idx] && seq[idx] > squash_seq) begin
                kill_mask[idx] = 1'b1;
                n = n + 1;
            end else begin
                halt = 1'b1;
            end
        end
        kill_n    = CW'(n);
        tail_next = IW'(ring_step(int'(tail), -n, DEPTH));
    end
endmodule

// File: rtl/store_wb_queue.sv
module store_wb_queue
    import swq_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int PORTS = 2,
    parameter  int AW    = 32,
    parameter  int DW    = 32,
    parameter  int SEQW  = 16,
    parameter  int SZW   = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_valid,
    input  logic [SEQW-1:0]            alloc_seq,
    input  logic                       alloc_nonspec,
    input  logic                       exec_valid,
    input  logic [IW-1:0]              exec_idx,
    input  logic [AW-1:0]              exec_addr,
    input  logic [DW-1:0]              exec_data,
    input  logic [SZW-1:0]             exec_size,
    input  logic                       exec_prefetch,
    input  logic                       exec_fault,
    input  logic                       commit_valid,
    input  logic [SEQW-1:0]            commit_seq,
    input  logic                       squash_valid,
    input  logic [SEQW-1:0]            squash_seq,
    input  logic                       dc_blocked,
    input  logic [PORTS-1:0]           dc_hit,
    input  logic                       resp_valid,
    input  logic [IW-1:0]              resp_idx,
    output logic [PORTS-1:0]           wr_valid,
    output logic [PORTS-1:0][IW-1:0]   wr_idx,
    output logic [PORTS-1:0][AW-1:0]   wr_addr,
    output logic [PORTS-1:0][DW-1:0]   wr_data,
    output logic [PORTS-1:0][SZW-1:0]  wr_size,
    output logic                       sq_full,
    output logic [CW-1:0]              sq_count,
    output logic [IW-1:0]              head_idx,
    output logic [IW-1:0]              tail_idx
);
    swq_flags_t [DEPTH-1:0]           flg, flg_n;
    logic [DEPTH-1:0][SEQW-1:0]       seq_q;
    logic [DEPTH-1:0][AW-1:0]         addr_q;
    logic [DEPTH-1:0][DW-1:0]         data_q;
    logic [DEPTH-1:0][SZW-1:0]        size_q;
    logic [IW-1:0]                    wb_q;
    logic [CW-1:0]                    pending_q;

    logic [DEPTH-1:0] v_valid, v_elig, v_issued, v_pref, v_done;
    logic [DEPTH-1:0] mark, exec_mark, elig_n, done_n, done_set;
    logic [DEPTH-1:0] hit_vec, resp_hit, issue_mask, skip_done;
    logic [DEPTH-1:0] retire_mask, kill_mask;
    logic [CW-1:0]    retire_n, kill_n;
    logic [IW-1:0]    head_next, tail_sq, wb_next;
    logic             alloc_fire, exec_ok;
    int               new_elig, n_comp;

    assign sq_full    = (int'(sq_count) == DEPTH);
    assign alloc_fire = alloc_valid && !sq_full && !squash_valid;
    assign exec_ok    = exec_valid && flg[exec_idx].valid;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            v_valid[i]  = flg[i].valid;
            v_elig[i]   = flg[i].elig;
            v_issued[i] = flg[i].issued;
            v_pref[i]   = flg[i].prefetch;
            v_done[i]   = flg[i].done;
        end
    end

    swq_commit_scan #(.DEPTH(DEPTH), .SEQW(SEQW), .IW(IW), .CW(CW)) u_commit (
        .elig(v_elig), .seq(seq_q), .head(head_idx), .count(sq_count),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .mark(mark));

    swq_wb_walk #(.DEPTH(DEPTH), .PORTS(PORTS), .SZW(SZW), .IW(IW), .CW(CW)) u_walk (
        .valid(v_valid), .elig(v_elig), .issued(v_issued), .prefetch(v_pref),
        .size(size_q), .wb_ptr(wb_q), .pending(pending_q), .blocked(dc_blocked),
        .lane_valid(wr_valid), .lane_idx(wr_idx), .issue_mask(issue_mask),
        .skip_done(skip_done), .wb_next(wb_next));

    // lane payload and completion sources
    always_comb begin
        hit_vec = '0;
        for (int l = 0; l < PORTS; l++) begin
            wr_addr[l] = addr_q[wr_idx[l]];
            wr_data[l] = data_q[wr_idx[l]];
            wr_size[l] = size_q[wr_idx[l]];
            if (wr_valid[l] && dc_hit[l]) hit_vec[wr_idx[l]] = 1'b1;
        end
        for (int i = 0; i < DEPTH; i++) begin
            exec_mark[i] = exec_ok && (exec_idx == IW'(i)) && flg[i].nonspec && !exec_fault;
            resp_hit[i]  = resp_valid && (resp_idx == IW'(i)) && flg[i].issued && !flg[i].done;
        end
        done_set = skip_done | hit_vec | resp_hit;
        done_n   = v_done | done_set;
        elig_n   = v_elig | mark | exec_mark;
        new_elig = $countones(elig_n & ~v_elig & v_valid);
        n_comp   = $countones(done_set & ~v_done & v_valid);
    end

    swq_retire_scan #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_retire (
        .valid(v_valid), .done_n(done_n), .head(head_idx), .count(sq_count),
        .retire_mask(retire_mask), .retire_n(retire_n), .head_next(head_next));

    swq_squash_scan #(.DEPTH(DEPTH), .SEQW(SEQW), .IW(IW), .CW(CW)) u_squash (
        .valid(v_valid), .seq(seq_q), .tail(tail_idx), .count(sq_count),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .kill_mask(kill_mask), .kill_n(kill_n), .tail_next(tail_sq));

    // next flag state, later assignments take priority
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            flg_n[i]        = flg[i];
            flg_n[i].elig   = elig_n[i];
            flg_n[i].issued = flg[i].issued | issue_mask[i];
            flg_n[i].done   = done_n[i];
            if (exec_ok && exec_idx == IW'(i)) flg_n[i].prefetch = exec_prefetch;
            if (retire_mask[i] || kill_mask[i]) flg_n[i] = '0;
            if (alloc_fire && tail_idx == IW'(i)) begin
                flg_n[i]         = '0;
                flg_n[i].valid   = 1'b1;
                flg_n[i].nonspec = alloc_nonspec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flg       <= '0;
            head_idx  <= '0;
            tail_idx  <= '0;
            wb_q      <= '0;
            sq_count  <= '0;
            pending_q <= '0;
        end else begin
            flg       <= flg_n;
            head_idx  <= head_next;
            wb_q      <= wb_next;
            pending_q <= CW'(int'(pending_q) + new_elig - n_comp);
            sq_count  <= CW'(int'(sq_count) + int'(alloc_fire) - int'(retire_n) - int'(kill_n));
            if (squash_valid)    tail_idx <= tail_sq;
            else if (alloc_fire) tail_idx <= IW'(ring_step(int'(tail_idx), 1, DEPTH));
            if (alloc_fire) seq_q[tail_idx] <= alloc_seq;
            if (exec_ok) begin
                addr_q[exec_idx] <= exec_addr;
                data_q[exec_idx] <= exec_data;
                size_q[exec_idx] <= exec_size;
            end
        end
    end
endmodule

// File: rtl/swq_checker.sv
module swq_checker #(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     alloc_valid,
    input logic                     squash_valid,
    input logic                     dc_blocked,
    input logic                     sq_full,
    input logic [CW-1:0]            sq_count,
    input logic [IW-1:0]            head_idx,
    input logic [IW-1:0]            tail_idx,
    input logic [PORTS-1:0]         wr_valid,
    input logic [PORTS-1:0][IW-1:0] wr_idx
);
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(sq_count) <= DEPTH);

    a_r1_full_no_growth: assert property (@(posedge clk) disable iff (rst)
        sq_full && alloc_valid |=> sq_count <= $past(sq_count));

    a_r6_blocked_silent: assert property (@(posedge clk) disable iff (rst)
        dc_blocked |-> wr_valid == '0);

    a_r10_squash_no_growth: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> sq_count <= $past(sq_count));

    a_r11_empty_ptrs: assert property (@(posedge clk) disable iff (rst)
        sq_count == '0 |-> head_idx == tail_idx);

    generate
        if (PORTS > 1) begin : g_lane_pair
            a_r4_distinct_lanes: assert property (@(posedge clk) disable iff (rst)
                wr_valid[0] && wr_valid[1] |-> wr_idx[0] != wr_idx[1]);
        end
    endgenerate
endmodule

bind store_wb_queue swq_checker #(.DEPTH(DEPTH), .PORTS(PORTS), .IW(IW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .squash_valid(squash_valid),
    .dc_blocked(dc_blocked), .sq_full(sq_full), .sq_count(sq_count),
    .head_idx(head_idx), .tail_idx(tail_idx), .wr_valid(wr_valid), .wr_idx(wr_idx));

// File: tb/sim_store_wb_queue.sv
`timescale 1ns/1ps
module sim_store_wb_queue;
    localparam int DEPTH = 8, PORTS = 2, AW = 32, DW = 32, SEQW = 16, SZW = 4;
    localparam int IW = 3, CW = 4;

    logic clk, rst;
    logic alloc_valid, alloc_nonspec, exec_valid, exec_prefetch, exec_fault;
    logic commit_valid, squash_valid, dc_blocked, resp_valid;
    logic [SEQW-1:0] alloc_seq, commit_seq, squash_seq;
    logic [IW-1:0] exec_idx, resp_idx;
    logic [AW-1:0] exec_addr;
    logic [DW-1:0] exec_data;
    logic [SZW-1:0] exec_size;
    logic [PORTS-1:0] dc_hit, wr_valid;
    logic [PORTS-1:0][IW-1:0] wr_idx;
    logic [PORTS-1:0][AW-1:0] wr_addr;
    logic [PORTS-1:0][DW-1:0] wr_data;
    logic [PORTS-1:0][SZW-1:0] wr_size;
    logic sq_full;
    logic [CW-1:0] sq_count;
    logic [IW-1:0] head_idx, tail_idx;

    store_wb_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .AW(AW), .DW(DW), .SEQW(SEQW), .SZW(SZW)) u0 (.*);

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
    exp_t expq[$];
    int checks = 0, errors = 0;
    int writes_seen = 0, burst_cycles = 0, max_lanes = 0;
    int tptr = 0;
    bit finished = 0;

    function automatic logic [AW-1:0] addr_of(int s); return AW'(s * 16); endfunction
    function automatic logic [DW-1:0] data_of(int s); return 32'hA500_0000 + DW'(s); endfunction

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: sampled half a cycle after inputs change
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst) begin : mon
                int lanes;
                lanes = 0;
                for (int l = 0; l < PORTS; l++) begin
                    if (wr_valid[l]) begin
                        lanes++;
                        writes_seen++;
                        if (expq.size() == 0) begin
                            checks++; errors++;
                            $display("FAIL R4: actual write of slot %0d expected none", wr_idx[l]);
                        end else begin
                            exp_t e;
                            e = expq.pop_front();
                            check_eq("R4 write address", longint'(wr_addr[l]), longint'(e.a));
                            check_eq("R4 write data", longint'(wr_data[l]), longint'(e.d));
                        end
                    end
                end
                if (lanes > 0) burst_cycles++;
                if (lanes > max_lanes) max_lanes = lanes;
            end
        end
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic clr(); writes_seen = 0; burst_cycles = 0; max_lanes = 0; endtask
    task automatic push_exp(int s); expq.push_back({addr_of(s), data_of(s)}); endtask

    task automatic do_alloc(int s, bit ns, bit accept, output int idx);
        alloc_valid = 1; alloc_seq = SEQW'(s); alloc_nonspec = ns;
        idx = tptr;
        if (accept) tptr = (tptr + 1) % DEPTH;
        cyc(1);
        alloc_valid = 0;
    endtask

    task automatic do_exec(int idx, int s, int sz, bit pf, bit flt);
        exec_valid = 1; exec_idx = IW'(idx); exec_addr = addr_of(s); exec_data = data_of(s);
        exec_size = SZW'(sz); exec_prefetch = pf; exec_fault = flt;
        cyc(1);
        exec_valid = 0;
    endtask

    task automatic store(int s, int sz, bit pf, bit ns, bit flt);
        int idx;
        do_alloc(s, ns, 1, idx);
        do_exec(idx, s, sz, pf, flt);
    endtask

    task automatic do_commit(int s);
        commit_valid = 1; commit_seq = SEQW'(s); cyc(1); commit_valid = 0;
    endtask

    task automatic do_squash(int s, int killed);
        squash_valid = 1; squash_seq = SEQW'(s);
        tptr = (tptr - killed + DEPTH) % DEPTH;
        cyc(1);
        squash_valid = 0;
    endtask

    task automatic do_resp(int idx);
        resp_valid = 1; resp_idx = IW'(idx); cyc(1); resp_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dummy;
        rst = 1; alloc_valid = 0; alloc_seq = '0; alloc_nonspec = 0;
        exec_valid = 0; exec_idx = '0; exec_addr = '0; exec_data = '0; exec_size = '0;
        exec_prefetch = 0; exec_fault = 0; commit_valid = 0; commit_seq = '0;
        squash_valid = 0; squash_seq = '0; dc_blocked = 0; dc_hit = '1;
        resp_valid = 0; resp_idx = '0;
        cyc(4);
        rst = 0;
        cyc(1);

        // R11 reset state
        check_eq("R11 count", sq_count, 0);
        check_eq("R11 head", head_idx, 0);
        check_eq("R11 tail", tail_idx, 0);
        check_eq("R11 full", sq_full, 0);
        check_eq("R11 no write", wr_valid, 0);

        // R1 allocation, R2 commit stops at the younger store
        store(10, 4, 0, 0, 0); store(11, 4, 0, 0, 0); store(12, 4, 0, 0, 0);
        check_eq("R1 tail after three", tail_idx, 3);
        check_eq("R1 count after three", sq_count, 3);
        push_exp(10); push_exp(11);
        do_commit(11);
        cyc(4);
        check_eq("R2 younger store kept", sq_count, 1);
        check_eq("R2 head", head_idx, 2);
        check_eq("R2 writes", writes_seen, 2);
        push_exp(12);
        do_commit(12);
        cyc(4);
        check_eq("R2 drained", sq_count, 0);

        // R4 lane limit, R1 tail wrap
        clr();
        for (int s = 20; s < 25; s++) store(s, 4, 0, 0, 0);
        check_eq("R1 tail wrap", tail_idx, 0);
        for (int s = 20; s < 25; s++) push_exp(s);
        do_commit(24);
        cyc(6);
        check_eq("R4 max lanes", max_lanes, 2);
        check_eq("R4 write cycles", burst_cycles, 3);
        check_eq("R4 count", sq_count, 0);

        // R8 misses, R9 contiguous retirement, same-cycle completions
        clr();
        dc_hit = '0;
        store(30, 4, 0, 0, 0); store(31, 4, 0, 0, 0); store(32, 4, 0, 0, 0);
        push_exp(30); push_exp(31); push_exp(32);
        do_commit(32);
        cyc(4);
        check_eq("R8 misses issued", writes_seen, 3);
        check_eq("R8 misses outstanding", sq_count, 3);
        do_resp(1);
        check_eq("R9 head held", head_idx, 0);
        check_eq("R9 count held", sq_count, 3);
        do_resp(2);
        check_eq("R9 count held again", sq_count, 3);
        store(33, 4, 0, 0, 0);
        push_exp(33);
        commit_valid = 1; commit_seq = 16'd33;
        cyc(1);
        commit_valid = 0; resp_valid = 1; resp_idx = 3'd0; dc_hit = '1;
        cyc(1);
        resp_valid = 0;
        check_eq("R9 same-cycle retire count", sq_count, 0);
        check_eq("R9 same-cycle head", head_idx, 4);
        check_eq("R8 hit write seen", writes_seen, 4);

        // R5 zero-size store takes no lane
        clr();
        store(40, 0, 0, 0, 0); store(41, 4, 0, 0, 0); store(42, 4, 0, 0, 0);
        push_exp(41); push_exp(42);
        do_commit(42);
        cyc(4);
        check_eq("R5 one write cycle", burst_cycles, 1);
        check_eq("R5 two lanes used", max_lanes, 2);
        check_eq("R5 count", sq_count, 0);

        // R7 prefetch takes a slot, writes nothing
        clr();
        store(50, 4, 1, 0, 0); store(51, 4, 0, 0, 0); store(52, 4, 0, 0, 0);
        push_exp(51); push_exp(52);
        do_commit(52);
        cyc(5);
        check_eq("R7 writes", writes_seen, 2);
        check_eq("R7 write cycles", burst_cycles, 2);
        check_eq("R7 count", sq_count, 0);

        // R6 blocked cache
        clr();
        dc_blocked = 1;
        store(60, 4, 0, 0, 0);
        push_exp(60);
        do_commit(60);
        cyc(5);
        check_eq("R6 no writes while blocked", writes_seen, 0);
        check_eq("R6 count while blocked", sq_count, 1);
        dc_blocked = 0;
        cyc(3);
        check_eq("R6 write after release", writes_seen, 1);
        check_eq("R6 count after release", sq_count, 0);

        // R3 non-speculative store
        clr();
        push_exp(70);
        store(70, 4, 0, 1, 0);
        cyc(4);
        check_eq("R3 written without commit", writes_seen, 1);
        check_eq("R3 count", sq_count, 0);
        store(71, 4, 0, 1, 1);
        cyc(4);
        check_eq("R3 faulted not written", writes_seen, 1);
        check_eq("R3 faulted kept", sq_count, 1);
        do_squash(70, 1);
        check_eq("R10 faulted squashed", sq_count, 0);
        check_eq("R10 tail rewound", tail_idx, 4);

        // R10 squash with a colliding allocation
        clr();
        for (int s = 80; s < 84; s++) store(s, 4, 0, 0, 0);
        squash_valid = 1; squash_seq = 16'd81; alloc_valid = 1; alloc_seq = 16'd84;
        tptr = (tptr - 2 + DEPTH) % DEPTH;
        cyc(1);
        squash_valid = 0; alloc_valid = 0;
        check_eq("R10 count after squash", sq_count, 2);
        check_eq("R10 tail after squash", tail_idx, 6);
        push_exp(80); push_exp(81);
        do_commit(83);
        cyc(4);
        check_eq("R10 survivors written", writes_seen, 2);
        check_eq("R10 count drained", sq_count, 0);

        // R1 full queue refuses allocation
        for (int s = 100; s < 108; s++) do_alloc(s, 0, 1, dummy);
        check_eq("R1 full flag", sq_full, 1);
        check_eq("R1 full count", sq_count, 8);
        do_alloc(108, 0, 0, dummy);
        check_eq("R1 count unchanged when full", sq_count, 8);
        check_eq("R1 tail unchanged when full", tail_idx, 6);
        do_squash(99, 8);
        check_eq("R10 full squash count", sq_count, 0);
        check_eq("R10 full squash tail", tail_idx, 6);
        check_eq("R1 full flag cleared", sq_full, 0);

        cyc(2);
        check_eq("R4 scoreboard drained", expq.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule